// File: doc/BRIEF.md
# Two-Stage Cascade Noise-Shaping Recombiner

This block merges the two quantizer streams of a cascaded sigma-delta modulator whose front stage is a second-order loop and whose back stage is a first-order loop, each producing a 3-bit code per modulator clock (500 kHz in the target system). The front-stage code is delayed by one accepted sample. The back-stage code is passed through a second-order differentiator, 1 - 2z^-1 + z^-2. The two results are summed. This cancels the front stage's quantization error, so only the back stage's error remains, shaped to third order, and feeds the downstream decimation filter.

A mode pin selects front-stage-only operation. In that mode the output is just the front-stage code, widened with its sign, and all delay history is kept at zero. When the cascade mode is selected again, the recombiner restarts as if it had just been reset. The sample history moves only on cycles flagged by the input strobe. The output is registered, with a one-cycle latency.

Top module: `mash21_cancel`

## Requirements
- R1: `y1_code` and `y2_code` are two's-complement codes of CODE_W bits (default 3, range -4..+3). They are sampled only on clock edges where `in_valid` is 1.
- R2: With `first_only` = 0, each accepted sample k produces y_out = A[k-1] + B[k] - 2*B[k-1] + B[k-2]. A is the `y1_code` stream and B is the `y2_code` stream, both counted in accepted samples. History not yet filled is 0.
- R3: `y_out` is CODE_W+3 bits two's complement. In cascade mode it stays within -18..+17 (default widths) and never wraps.
- R4: `y_out` and `out_valid` change on the clock edge that accepts a sample, so the latency is one cycle. `out_valid` equals `in_valid` as sampled on the previous edge.
- R5: With `first_only` = 1, an accepted sample gives `y_out` = `y1_code` sign-extended, and `y2_code` has no effect on `y_out`.
- R6: On any edge where `first_only` = 1, whether or not `in_valid` is high, all delay history is cleared. The next cascade-mode sample therefore sees A[k-1] = B[k-1] = B[k-2] = 0.
- R7: On an edge with `in_valid` = 0, `y_out` holds its value and the delay history does not advance.
- R8: While `rst_n` is 0 (asynchronous, active low), `y_out` = 0, `out_valid` = 0 and the history is 0.
- R9: In cascade mode, a back-stage stream that is constant or changes by a fixed step over three accepted samples contributes nothing. `y_out` then equals the delayed front-stage code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks a cycle carrying a new pair of stage codes |
| first_only | input | 1 | 1 selects front-stage-only output and clears history |
| y1_code | input | 3 | Front (second-order) stage quantizer code, signed |
| y2_code | input | 3 | Back (first-order) stage quantizer code, signed |
| out_valid | output | 1 | Marks a cycle carrying a new combined code |
| y_out | output | 6 | Combined code, signed |

## Verification
A stale or misaligned history word appears as a wrong `y_out` on the very next accepted sample. A stuck back-stage tap shows up no later than two samples after it was loaded, because B[k-2] enters the sum at that point. A failure to clear history in front-stage-only mode shows on the first cascade-mode sample after the mode returns. A history register that advances on idle cycles distorts the sample that follows the gap. Constant and ramp back-stage patterns expose a wrong differentiator weight at once, since the output must then equal the delayed front-stage code exactly.

// File: rtl/mash21_pkg.sv
package mash21_pkg;

    // Output mode selected by the first_only pin
    typedef enum logic {
        MODE_CASCADE    = 1'b0,
        MODE_FIRST_ONLY = 1'b1
    } mash21_mode_e;

    // Extra output bits over the code width: the delayed front code plus a
    // second difference spans at most 5 * 2^(CODE_W-1) in magnitude
    localparam int GROWTH_BITS = 3;

    // Number of back-stage history taps for a second-order differentiator
    localparam int DIFF_ORDER = 2;

endpackage

// File: rtl/mash21_tap_line.sv
module mash21_tap_line #(
    parameter int W     = 3,
    parameter int DEPTH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic                     clear,
    input  logic [W-1:0]             din,
    output logic [DEPTH-1:0][W-1:0]  taps
);

    logic [W-1:0] tap_d [DEPTH];
    logic [W-1:0] tap_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_comb begin
            tap_d[i] = tap_q[i];
            if (clear) begin
                tap_d[i] = '0;
            end else if (shift_en) begin
                if (i == 0) tap_d[i] = din;
                else        tap_d[i] = tap_q[(i == 0) ? 0 : i-1];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tap_q[i] <= '0;
            else        tap_q[i] <= tap_d[i];
        end

        assign taps[i] = tap_q[i];
    end

    // R6
    hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (taps == '0));

    // R7
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clear) |=> $stable(taps));

endmodule

// File: rtl/mash21_combine.sv
module mash21_combine #(
    parameter int CODE_W = 3,
    parameter int OUT_W  = 6
) (
    input  logic                     first_only,
    input  logic signed [CODE_W-1:0] a_now,
    input  logic signed [CODE_W-1:0] a_prev,
    input  logic signed [CODE_W-1:0] b_now,
    input  logic signed [CODE_W-1:0] b_prev1,
    input  logic signed [CODE_W-1:0] b_prev2,
    output logic signed [OUT_W-1:0]  sum
);

    localparam int EXT = OUT_W - CODE_W;

    logic signed [OUT_W-1:0] a_now_x;
    logic signed [OUT_W-1:0] a_prev_x;
    logic signed [OUT_W-1:0] b_now_x;
    logic signed [OUT_W-1:0] b_p1_x;
    logic signed [OUT_W-1:0] b_p2_x;
    logic signed [OUT_W-1:0] b_dd;

    always_comb begin
        a_now_x  = {{EXT{a_now[CODE_W-1]}},   a_now};
        a_prev_x = {{EXT{a_prev[CODE_W-1]}},  a_prev};
        b_now_x  = {{EXT{b_now[CODE_W-1]}},   b_now};
        b_p1_x   = {{EXT{b_prev1[CODE_W-1]}}, b_prev1};
        b_p2_x   = {{EXT{b_prev2[CODE_W-1]}}, b_prev2};
        // second-order difference of the back-stage stream
        b_dd     = b_now_x - (b_p1_x <<< 1) + b_p2_x;
        if (first_only) sum = a_now_x;
        else            sum = a_prev_x + b_dd;
    end

endmodule

// File: rtl/mash21_cancel.sv
module mash21_cancel
    import mash21_pkg::*;
#(
    parameter  int CODE_W = 3,
    localparam int OUT_W  = CODE_W + GROWTH_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              first_only,
    input  logic [CODE_W-1:0] y1_code,
    input  logic [CODE_W-1:0] y2_code,
    output logic              out_valid,
    output logic [OUT_W-1:0]  y_out
);

    localparam int HALF  = 2 ** (CODE_W - 1);
    localparam int Y_MAX = 3 * (HALF - 1) + 2 * HALF;
    localparam int Y_MIN = -(3 * HALF) - 2 * (HALF - 1);

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] y;
    } out_st_t;

    out_st_t st_d, st_q;

    mash21_mode_e mode;
    logic [0:0][CODE_W-1:0]          a_hist;
    logic [DIFF_ORDER-1:0][CODE_W-1:0] b_hist;
    logic signed [OUT_W-1:0]         comb_sum;

    assign mode = first_only ? MODE_FIRST_ONLY : MODE_CASCADE;

    mash21_tap_line #(.W(CODE_W), .DEPTH(1)) u_a_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .clear    (mode == MODE_FIRST_ONLY),
        .din      (y1_code),
        .taps     (a_hist)
    );

    mash21_tap_line #(.W(CODE_W), .DEPTH(DIFF_ORDER)) u_b_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .clear    (mode == MODE_FIRST_ONLY),
        .din      (y2_code),
        .taps     (b_hist)
    );

    mash21_combine #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_comb (
        .first_only (mode == MODE_FIRST_ONLY),
        .a_now      (y1_code),
        .a_prev     (a_hist[0]),
        .b_now      (y2_code),
        .b_prev1    (b_hist[0]),
        .b_prev2    (b_hist[1]),
        .sum        (comb_sum)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.y = comb_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign y_out     = st_q.y;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (($signed(y_out) <= Y_MAX) && ($signed(y_out) >= Y_MIN)));

    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R4
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5
    first_only_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && first_only) |=>
            (y_out == {{GROWTH_BITS{$past(y1_code[CODE_W-1])}}, $past(y1_code)}));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(y_out));

endmodule

// File: tb/tb_mash21_cancel.sv
module tb_mash21_cancel;

    localparam int NV = 15;
    // stimulus table: mode, front code, back code, expected combined code
    localparam int VB [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0};
    localparam int V1 [NV] = '{3, -4, 2, 3, 3, -4, 0, 1, -3, 2, -1, 0, 0, -4, 0};
    localparam int V2 [NV] = '{1, -4, 3, -4, 3, -4, -4, -4, 2, -1, 0, 1, -4, 3, -4};
    localparam int VE [NV] = '{1, -3, 8, -12, 17, -11, 3, 0, -3, -1, 4, -1, -6, 12, -18};
    localparam string VT [NV] = '{"R2", "R2", "R2", "R2", "R3", "R2", "R2", "R9",
                                  "R5", "R6", "R2", "R9", "R2", "R2", "R3"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       first_only = 1'b0;
    logic [2:0] y1_code = '0;
    logic [2:0] y2_code = '0;
    logic       out_valid;
    logic [5:0] y_out;

    int checks = 0;
    int fails  = 0;
    int hy1 = 0, hd1 = 0, hd2 = 0, last = 0;

    always #10 clk = ~clk;

    mash21_cancel dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .first_only (first_only),
        .y1_code    (y1_code),
        .y2_code    (y2_code),
        .out_valid  (out_valid),
        .y_out      (y_out)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic drive(input int v, input int b, input int a, input int c);
        @(negedge clk);
        in_valid   = (v != 0);
        first_only = (b != 0);
        y1_code    = 3'(a);
        y2_code    = 3'(c);
        @(posedge clk);
        #1;
    endtask

    // independent reference of the requirements
    task automatic model(input int v, input int b, input int a, input int c, output int exp);
        exp = last;
        if (v != 0) begin
            if (b != 0) exp = a;
            else        exp = hy1 + c - 2 * hd1 + hd2;
            last = exp;
        end
        if (b != 0) begin
            hy1 = 0; hd1 = 0; hd2 = 0;
        end else if (v != 0) begin
            hd2 = hd1; hd1 = c; hy1 = a;
        end
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int e;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset y_out", $signed(y_out), 0);
        check("R8 reset out_valid", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(1, VB[i], V1[i], V2[i]);
            check(VT[i], $signed(y_out), VE[i]);
            check("R4 out_valid high", out_valid, 1);
        end
        // history now: front 0, back -4 then 3
        drive(0, 0, 3, 3);
        check("R4 out_valid low", out_valid, 0);
        check("R7 idle hold", $signed(y_out), -18);
        drive(0, 0, -2, 1);
        drive(1, 0, 1, 0);
        check("R7 history frozen while idle", $signed(y_out), 11);
        drive(0, 1, 3, 3);
        check("R7 hold during idle clear", $signed(y_out), 11);
        drive(1, 0, 2, 2);
        check("R6 idle clear of history", $signed(y_out), 2);
        check("R1 sample accepted", out_valid, 1);

        hy1 = 2; hd1 = 2; hd2 = 0; last = 2;
        for (int n = 0; n < 400; n++) begin
            int v, b, a, c;
            v = (($urandom % 8) != 0) ? 1 : 0;
            b = (($urandom % 10) == 0) ? 1 : 0;
            a = int'($urandom % 8) - 4;
            c = int'($urandom % 8) - 4;
            model(v, b, a, c, e);
            drive(v, b, a, c);
            if (v != 0 && b != 0) check("R5 random first-only", $signed(y_out), e);
            else                  check("R2 random stream", $signed(y_out), e);
            check("R4 random valid", out_valid, v);
        end

        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        #1;
        check("R8 async reset y_out", $signed(y_out), 0);
        check("R8 async reset out_valid", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1, 0, 0, 3);
        check("R8 history zero after reset", $signed(y_out), 3);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule